// File: doc/BRIEF.md
# Serial Port Interrupt and Modem Status Logic

This block combines the interrupt sources of a UART-style serial port into one active-low interrupt request. It also supplies the three upper status bits that software sees when it reads the status register. A transmit-complete pulse and a receive-complete pulse arrive already aligned to the system clock. Each pulse is qualified by decoded command bits. A qualified event is caught in a sample register and then handed to an interrupt flag. This two-step handoff means a pulse that lands while software is reading status is held over until the read ends, and it is never dropped.

The two modem inputs, data-set-ready and carrier-detect, are brought into the clock domain through synchronizer chains. Their current levels are reported in status bits 6 and 5. A change in either level, compared against the level seen at the end of the last status read, also raises the interrupt. The combined interrupt value is registered and does not move while a read is in progress. The value the host reads in bit 7 is therefore the same value that drives the interrupt pin.

Top module: `acia_irq_status`

## Requirements
- R1: `stat_hi[1]` reports the `dsr_pin` level and `stat_hi[0]` reports the `dcd_pin` level, each delayed by exactly `SYNC_STAGES` clock edges (2 by default).
- R2: `stat_hi[2]` always equals the inverse of `irq_n`, so the interrupt pin is low exactly when bit 7 reads 1.
- R3: A `tx_done` pulse counts as an event only when `cmd[3]`=0, `cmd[2]`=1 and `cmd[0]`=1. For every other command value it has no effect on `irq_n`.
- R4: An `rx_end` pulse counts as an event only when `cmd[1]`=0 and `cmd[0]`=1. For every other command value it has no effect on `irq_n`.
- R5: When no read is in progress, a qualified event sampled at clock edge N drives `irq_n` low after edge N+2, and not earlier.
- R6: While `stat_rd` is high, the interrupt flag is cleared. If no modem change is pending, `irq_n` returns high at the first clock edge at which `stat_rd` is low.
- R7: A qualified event that arrives while `stat_rd` is high is kept. It drives `irq_n` low at the second clock edge after `stat_rd` goes low.
- R8: While `stat_rd` is high, `irq_n` and `stat_hi[2]` keep the value they had when the read began.
- R9: A modem change is pending while the synchronized level of either pin differs from its reference. Each reference takes the synchronized level at every clock edge during a read, so it ends up holding the level from the end of the last read. After reset both references are 0.
- R10: Reset (`rst` high at a clock edge) clears the sample register, the interrupt flag, the references, the synchronizers and the registered interrupt, so `irq_n`=1 and `stat_hi`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_done | input | 1 | One-cycle transmit-complete pulse |
| rx_end | input | 1 | One-cycle receive-complete pulse |
| cmd | input | 4 | Decoded command-register bits 3..0 |
| dsr_pin | input | 1 | Raw data-set-ready pin level |
| dcd_pin | input | 1 | Raw carrier-detect pin level |
| stat_rd | input | 1 | High for the cycles of a status read |
| stat_hi | output | 3 | Status bits 7..5: {interrupt, DSR level, DCD level} |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The assertions assume that `tx_done` and `rx_end` are already synchronous to `clk`. They also assume that `cmd` is stable whenever a pulse is sampled, since the qualification uses the command bits present in that same cycle. The bench drives every input on the falling clock edge and holds `cmd` steady across each pulse. It raises the modem pins only while they are held at 0 through reset, so the reference starts equal to the pins. Reads are full clock cycles of `stat_rd`, and no read overlaps a reset.

// File: rtl/acia_irq_status.sv
module acia_irq_status #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tx_done,
  input  logic       rx_end,
  input  logic [3:0] cmd,
  input  logic       dsr_pin,
  input  logic       dcd_pin,
  input  logic       stat_rd,
  output logic [2:0] stat_hi,
  output logic       irq_n
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] dsr_pipe, dcd_pipe;
  logic dsr_s, dcd_s, dsr_ref, dcd_ref;
  logic samp_q, flag_q, irq_q;
  logic tx_ev, rx_ev, dsr_chg, dcd_chg;

  assign dsr_s   = dsr_pipe[TOP];
  assign dcd_s   = dcd_pipe[TOP];
  assign tx_ev   = tx_done & ~cmd[3] & cmd[2] & cmd[0];
  assign rx_ev   = rx_end & ~cmd[1] & cmd[0];
  assign dsr_chg = dsr_s ^ dsr_ref;
  assign dcd_chg = dcd_s ^ dcd_ref;

  always_ff @(posedge clk) begin
    if (rst) begin
      dsr_pipe <= '0;
      dcd_pipe <= '0;
    end else begin
      dsr_pipe <= {dsr_pipe[TOP-1:0], dsr_pin};
      dcd_pipe <= {dcd_pipe[TOP-1:0], dcd_pin};
    end
  end

  // sample register: a new event always wins; a read blocks the handoff
  always_ff @(posedge clk) begin
    if (rst) samp_q <= 1'b0;
    else     samp_q <= tx_ev | rx_ev | (samp_q & stat_rd);
  end

  always_ff @(posedge clk) begin
    if (rst || stat_rd) flag_q <= 1'b0;
    else if (samp_q)    flag_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dsr_ref <= 1'b0;
      dcd_ref <= 1'b0;
    end else if (stat_rd) begin
      dsr_ref <= dsr_s;
      dcd_ref <= dcd_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           irq_q <= 1'b0;
    else if (!stat_rd) irq_q <= flag_q | dsr_chg | dcd_chg;
  end

  assign stat_hi = {irq_q, dsr_s, dcd_s};
  assign irq_n   = ~irq_q;
endmodule

module acia_irq_status_chk (
  input logic       clk,
  input logic       rst,
  input logic       tx_done,
  input logic       rx_end,
  input logic [3:0] cmd,
  input logic       stat_rd,
  input logic       irq_n,
  input logic       samp_q,
  input logic       flag_q,
  input logic       dsr_s,
  input logic       dsr_ref
);
  // R6
  read_clears_flag_chk: assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> !flag_q);

  // R7
  event_kept_chk: assert property (@(posedge clk) disable iff (rst)
    ((tx_done && !cmd[3] && cmd[2] && cmd[0]) || (rx_end && !cmd[1] && cmd[0])) |=> samp_q);

  // R8
  irq_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    $past(stat_rd) |-> $stable(irq_n));

  // R9
  ref_settled_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(stat_rd) && $stable(dsr_s)) |-> (dsr_s == dsr_ref));
endmodule

bind acia_irq_status acia_irq_status_chk i_chk (
  .clk(clk), .rst(rst), .tx_done(tx_done), .rx_end(rx_end), .cmd(cmd),
  .stat_rd(stat_rd), .irq_n(irq_n), .samp_q(samp_q), .flag_q(flag_q),
  .dsr_s(dsr_s), .dsr_ref(dsr_ref)
);

// File: tb/test_acia_irq_status.sv
module test_acia_irq_status;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_done = 1'b0, rx_end = 1'b0, dsr_pin = 1'b0, dcd_pin = 1'b0, stat_rd = 1'b0;
  logic [3:0] cmd = 4'd0;
  logic [2:0] stat_hi;
  logic irq_n;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  acia_irq_status i_acia_irq_status (
    .clk(clk), .rst(rst), .tx_done(tx_done), .rx_end(rx_end), .cmd(cmd),
    .dsr_pin(dsr_pin), .dcd_pin(dcd_pin), .stat_rd(stat_rd),
    .stat_hi(stat_hi), .irq_n(irq_n)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_read();
    stat_rd = 1'b1; cyc(1);
    stat_rd = 1'b0; cyc(1);
  endtask

  initial begin
    #(PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    // R10 reset state
    chk("R10 irq_n", irq_n, 1);
    chk("R10 stat_hi", stat_hi, 0);
    rst = 1'b0; cyc(2);
    chk("R10 idle", irq_n, 1);

    // R3 R4 R5 R6 R2 sweep of command values and sources
    for (int c = 0; c < 16; c++) begin
      for (int s = 0; s < 2; s++) begin
        logic [3:0] cv;
        logic en;
        cv = c[3:0];
        en = s ? (!cv[1] && cv[0]) : (!cv[3] && cv[2] && cv[0]);
        cmd = cv;
        if (s) rx_end = 1'b1; else tx_done = 1'b1;
        cyc(1);
        tx_done = 1'b0; rx_end = 1'b0;
        cyc(1);
        chk("R5 not early", irq_n, 1);
        cyc(1);
        chk(s ? "R4 rx qualify" : "R3 tx qualify", irq_n, !en);
        chk("R2 bit7", stat_hi[2], !irq_n);
        do_read();
        chk("R6 cleared", irq_n, 1);
      end
    end

    // R7 R8 event during read, irq low before read stays frozen
    cmd = 4'b0101;
    tx_done = 1'b1; cyc(1); tx_done = 1'b0; cyc(2);
    chk("R5 set", irq_n, 0);
    stat_rd = 1'b1; cyc(1);
    chk("R8 frozen low", irq_n, 0);
    rx_end = 1'b1; cyc(1); rx_end = 1'b0; cyc(3);
    chk("R8 still frozen", irq_n, 0);
    chk("R2 bit7 read", stat_hi[2], 1);
    stat_rd = 1'b0; cyc(1);
    chk("R7 first edge", irq_n, 1);
    cyc(1);
    chk("R7 deferred", irq_n, 0);
    do_read();
    chk("R6 cleared again", irq_n, 1);

    // R8 idle irq stays high during read despite event
    stat_rd = 1'b1;
    tx_done = 1'b1; cyc(1); tx_done = 1'b0; cyc(3);
    chk("R8 frozen high", irq_n, 1);
    stat_rd = 1'b0; cyc(2);
    chk("R7 after read", irq_n, 0);
    do_read();

    // R1 R9 modem sweep from each reference to each new level
    cmd = 4'd0;
    for (int r = 0; r < 4; r++) begin
      for (int n = 0; n < 4; n++) begin
        logic [1:0] rv, nv;
        rv = r[1:0]; nv = n[1:0];
        {dsr_pin, dcd_pin} = rv; cyc(2);
        do_read(); cyc(1);
        chk("R9 ref settled", irq_n, 1);
        {dsr_pin, dcd_pin} = nv; cyc(1);
        chk("R1 not early", stat_hi[1:0], rv);
        cyc(1);
        chk("R1 level", stat_hi[1:0], nv);
        cyc(1);
        chk("R9 change", irq_n, !(rv != nv));
      end
    end
    do_read();
    chk("R9 cleared", irq_n, 1);

    // R10 reset with flag set and pending sample
    cmd = 4'b0101;
    tx_done = 1'b1; cyc(1); tx_done = 1'b0; cyc(2);
    rx_end = 1'b1; cyc(1); rx_end = 1'b0;
    {dsr_pin, dcd_pin} = 2'b00;
    rst = 1'b1; cyc(1);
    chk("R10 reset irq", irq_n, 1);
    rst = 1'b0; cyc(4);
    chk("R10 nothing pending", irq_n, 1);
    chk("R10 stat", stat_hi, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule